// File: doc/BRIEF.md
# Bit-Level Serial EEPROM Slave

This block models a small serial EEPROM as seen from a host that drives the two-wire bus by software. The host has no bus controller. It writes each new pair of clock and data levels into the block as one update, one clock cycle with `bus_upd` high. After each update it can read back the level the slave puts on the data line. The block keeps the clock and data levels of the previous update. It classifies every update as a start, a stop, a clock rising edge with a stable data level, a clock rising edge during which data also changed, or nothing of interest. A tick counter then steps through the command bits, the acknowledge slot and the eight address or data bits.

On a write command the next byte becomes the word address, and the byte stored there is fetched into the output data register. On a read command the slave shifts the data register out MSB first. After each byte it lets go of the line for the host's acknowledge slot and moves on to the next location, wrapping at the top of memory. The memory is filled beforehand through a parallel initialisation port. The bus side never writes the memory.

Top module: `ee_bitbang_slave`

## Requirements
- R1: After reset `sda_out` is 1, the word address and the data register are 0, and no transfer is in progress. A read command sent straight after reset returns 0x00 and then the byte at location 1.
- R2: While no transfer is in progress (before the first start, or after a stop), clock and data activity is not counted. Nine or more clock pulses leave `sda_out` at 1 and produce no acknowledge.
- R3: When the clock is high in two successive updates and data changes between them, the update is a bus condition: a falling data level is a start and a rising one is a stop. A start restarts the bit count at the first command bit. A stop ends the transfer and sets `sda_out` to 1.
- R4: A bit is accepted only on a clock rising edge (low in the previous update, high in this one) where the data level equals that of the previous update. A rising edge during which data also changes accepts no bit and does not advance the count.
- R5: The eight accepted bits after a start form the command, MSB first. Only the last command bit matters: 1 means read and 0 means write. On the next clock rising edge `sda_out` goes to 0 as the acknowledge.
- R6: After a write command, the next eight accepted bits form the word address, MSB first. On the clock rising edge that follows, `sda_out` goes to 0 as the acknowledge, and the data register already holds the memory byte at that address.
- R7: After a read command, each of the next eight clock rising edges with accepted bits sets `sda_out` to the next bit of the data register, MSB first.
- R8: After eight read bits, the next clock rising edge sets `sda_out` to 1, which frees the host's acknowledge slot. The word address has then advanced by one, modulo 256, and the data register holds the byte at the new address.
- R9: A cycle with `init_we` high writes `init_data` into memory location `init_addr`. The bus side reads that value from then on.
- R10: `sda_out` is 1 on every command bit and every address bit, and at every other time when the slave is neither acknowledging nor sending a read bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_upd | input | 1 | High for one cycle when `scl_in`/`sda_in` carry a new sampled bus state |
| scl_in | input | 1 | Sampled clock level written by the host |
| sda_in | input | 1 | Sampled data level written by the host |
| init_we | input | 1 | Memory initialisation write strobe |
| init_addr | input | 8 | Memory initialisation location |
| init_data | input | 8 | Memory initialisation byte |
| sda_out | output | 1 | Level the slave presents on the data line (1 = released) |

## Verification
The bench does a random read at every one of the 256 addresses, with two bytes per read. The transfer that starts at the last location shows whether the address wraps to zero or runs off the end. Some address bytes contain a rising edge that changes data at the same moment. A design that counted that edge would latch a shifted address and return the wrong bytes. Clock pulses sent after a stop show whether the bit count stays idle: if it counted them, an acknowledge would appear with no start. The host's acknowledge slot after each read byte checks that the line is released and not still driving the last data bit. A read straight after reset checks the reset values of the address and data registers.

// File: rtl/ee_pkg.sv
// Package: shared types and constants of the bit-level serial EEPROM slave.
// Assumes one bus update carries a complete (clock, data) level pair.
package ee_pkg;

    localparam int TICK_W = 5;

    // Tick values that the bit engine decodes
    localparam logic [TICK_W-1:0] TK_IDLE  = 5'd0;   // no transfer in progress
    localparam logic [TICK_W-1:0] TK_FIRST = 5'd1;   // first command bit after a start
    localparam logic [TICK_W-1:0] TK_ACK   = 5'd9;   // acknowledge slot
    localparam logic [TICK_W-1:0] TK_END   = 5'd17;  // a byte after the acknowledge is complete
    localparam logic [TICK_W-1:0] TK_ONE   = 5'd1;

    // Classification of one bus update against the previous one
    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,   // no clock rise, no bus condition
        EV_START = 3'd1,   // clock held high, data fell
        EV_STOP  = 3'd2,   // clock held high, data rose
        EV_BIT   = 3'd3,   // clock rose, data stable: a bit is taken
        EV_SKEW  = 3'd4    // clock rose while data changed: no bit
    } ee_event_e;

endpackage

// File: rtl/ee_event_classify.sv
// Module: ee_event_classify
// Sorts the current bus level pair against the previous one into a start,
// stop, clean clock rise, skewed clock rise or nothing. Purely combinational;
// assumes the caller holds the previous levels.
module ee_event_classify
    import ee_pkg::*;
(
    input  logic      prev_scl,
    input  logic      prev_sda,
    input  logic      scl,
    input  logic      sda,
    output ee_event_e ev
);

    // Bus conditions take precedence over clock edges
    always_comb begin
        ev = EV_NONE;
        if (prev_scl && scl && (prev_sda != sda)) begin
            ev = sda ? EV_STOP : EV_START;
        end else if (!prev_scl && scl) begin
            ev = (prev_sda == sda) ? EV_BIT : EV_SKEW;
        end
    end

endmodule

// File: rtl/ee_store.sv
// Module: ee_store
// Byte storage of the slave: one synchronous write port for initialisation and
// one asynchronous read port for the bit engine. Assumes contents are loaded
// before use; the array itself is not reset.
module ee_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Initialisation write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Fetch for the bit engine
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ee_bit_engine.sv
// Module: ee_bit_engine
// Tick-counted protocol engine. On each bus update it records the new levels
// and acts on the classified event: it takes the read/write flag from the
// command, captures the word address, shifts out read data and drives the
// acknowledge slots. Assumes a storage read port with zero latency at rd_addr.
module ee_bit_engine
    import ee_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          scl,
    input  logic          sda,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          sda_o
);

    localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};

    logic              prev_scl;
    logic              prev_sda;
    logic [TICK_W-1:0] tick;
    logic              ack;       // an acknowledge slot is pending
    logic              ack_rel;   // pending slot belongs to the host: release the line
    logic              rd_cmd;    // last command bit seen: 1 = read
    logic [AW-1:0]     addr;
    logic [DW-1:0]     data;
    ee_event_e         ev;
    logic              rise;

    ee_event_classify u_classify (
        .prev_scl (prev_scl),
        .prev_sda (prev_sda),
        .scl      (scl),
        .sda      (sda),
        .ev       (ev)
    );

    assign rise = (ev == EV_BIT) || (ev == EV_SKEW);

    // Next location: after a read byte the following one, after an address byte the new address
    assign rd_addr = rd_cmd ? (addr + ADDR_ONE) : {addr[AW-2:0], sda};

    // Protocol state, advanced once per bus update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_scl <= 1'b1;
            prev_sda <= 1'b1;
            tick     <= TK_IDLE;
            ack      <= 1'b0;
            ack_rel  <= 1'b0;
            rd_cmd   <= 1'b0;
            addr     <= '0;
            data     <= '0;
            sda_o    <= 1'b1;
        end else if (upd) begin
            prev_scl <= scl;
            prev_sda <= sda;
            if (ev == EV_START) begin
                tick  <= TK_FIRST;
                ack   <= 1'b0;
                sda_o <= 1'b1;
            end else if (ev == EV_STOP) begin
                tick  <= TK_IDLE;
                ack   <= 1'b0;
                sda_o <= 1'b1;
            end else if (tick == TK_IDLE && !ack) begin
                // idle: wait for a start
            end else if (ack && rise) begin
                sda_o <= ack_rel;
                ack   <= 1'b0;
            end else if (ev == EV_BIT) begin
                if (tick < TK_ACK) begin
                    rd_cmd <= sda;
                    sda_o  <= 1'b1;
                    tick   <= tick + TK_ONE;
                    if (tick == TK_ACK - TK_ONE) begin
                        ack     <= 1'b1;
                        ack_rel <= 1'b0;
                    end
                end else if (tick < TK_END) begin
                    if (rd_cmd) begin
                        sda_o <= data[DW-1];
                        data  <= {data[DW-2:0], 1'b0};
                    end else begin
                        addr  <= {addr[AW-2:0], sda};
                        sda_o <= 1'b1;
                    end
                    if (tick == TK_END - TK_ONE) begin
                        tick    <= TK_ACK;
                        ack     <= 1'b1;
                        ack_rel <= rd_cmd;
                        data    <= rd_data;
                        if (rd_cmd) begin
                            addr <= addr + ADDR_ONE;
                        end
                    end else begin
                        tick <= tick + TK_ONE;
                    end
                end
            end
        end
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= TK_END);  // R5
    AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> tick == TK_ACK);  // R5
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev == EV_START) |=> (tick == TK_FIRST && sda_o));  // R3
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev == EV_STOP) |=> (tick == TK_IDLE && sda_o));  // R3
    AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && tick == TK_IDLE && !ack && ev != EV_START) |=> (tick == TK_IDLE && sda_o));  // R2
    AST_SKEW_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev == EV_SKEW) |=> $stable(tick));  // R4
    AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(sda_o) && $stable(tick) && $stable(addr)));  // R4

endmodule

// File: rtl/ee_bitbang_slave.sv
// Module: ee_bitbang_slave
// Top of the bit-level serial EEPROM slave: storage plus protocol engine.
// Assumes the host presents one sampled (clock, data) pair per bus_upd pulse
// and fills the memory through the init port before reading.
module ee_bitbang_slave #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_upd,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          init_we,
    input  logic [AW-1:0] init_addr,
    input  logic [7:0]    init_data,
    output logic          sda_out
);

    localparam int DW = 8;

    logic [AW-1:0] fetch_addr;
    logic [DW-1:0] fetch_data;

    ee_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (init_we),
        .wr_addr (init_addr),
        .wr_data (init_data),
        .rd_addr (fetch_addr),
        .rd_data (fetch_data)
    );

    ee_bit_engine #(.AW(AW), .DW(DW)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (bus_upd),
        .scl     (scl_in),
        .sda     (sda_in),
        .rd_addr (fetch_addr),
        .rd_data (fetch_data),
        .sda_o   (sda_out)
    );

endmodule

// File: tb/ee_bitbang_slave_bench.sv
module ee_bitbang_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_upd = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       init_we = 1'b0;
    logic [7:0] init_addr = '0;
    logic [7:0] init_data = '0;
    logic       sda_out;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ee_bitbang_slave u_ee_bitbang_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_upd   (bus_upd),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data),
        .sda_out   (sda_out)
    );

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 37 + 91) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // one bus update; called and returns at a falling clock edge
    task automatic upd(input logic s, input logic d);
        bus_upd = 1'b1; scl_in = s; sda_in = d;
        @(negedge clk);
        bus_upd = 1'b0;
    endtask

    // one clock pulse carrying d; r is sda_out right after the rise
    task automatic pulse(input logic d, output logic r);
        upd(1'b0, d);
        upd(1'b1, d);
        r = sda_out;
        upd(1'b0, d);
    endtask

    task automatic bus_start();
        upd(1'b0, 1'b0);
        upd(1'b1, 1'b1);   // skewed rise: no bit
        upd(1'b1, 1'b0);
    endtask

    task automatic bus_stop();
        upd(1'b0, 1'b1);
        upd(1'b1, 1'b0);   // skewed rise: no bit
        upd(1'b1, 1'b1);
        chk("R3 stop releases", {7'd0, sda_out}, 8'd1);
    endtask

    // send a byte, optionally with a skewed rise before bit 'skew_at' (-1 = none)
    task automatic send_byte(input logic [7:0] v, input int skew_at, input string req);
        logic r;
        for (int k = 7; k >= 0; k--) begin
            if (k == skew_at) begin
                upd(1'b0, ~v[k]);
                upd(1'b1, v[k]);   // R4: data changes together with the rise
                upd(1'b0, v[k]);
            end
            pulse(v[k], r);
            if (k == 7 || k == 0) chk("R10 released during host bits", {7'd0, r}, 8'd1);
        end
        pulse(1'b1, r);
        chk(req, {7'd0, r}, 8'd0);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic r;
        for (int k = 7; k >= 0; k--) begin
            pulse(1'b1, r);
            v[k] = r;
        end
    endtask

    task automatic read_two(input logic [7:0] e0, input logic [7:0] e1, input string req);
        logic [7:0] v;
        logic r;
        read_byte(v);
        chk({req, " first byte (R7)"}, v, e0);
        pulse(1'b0, r);
        chk("R8 host ack slot released", {7'd0, r}, 8'd1);
        read_byte(v);
        chk({req, " next byte (R8)"}, v, e1);
        pulse(1'b1, r);
        chk("R8 final slot released", {7'd0, r}, 8'd1);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset sda_out", {7'd0, sda_out}, 8'd1);

        // R9: fill memory through the init port
        for (int i = 0; i < 256; i++) begin
            init_we = 1'b1; init_addr = 8'(i); init_data = pattern(i);
            @(negedge clk);
        end
        init_we = 1'b0;

        // R1: read straight after reset gives the reset data register, then location 1
        bus_start();
        send_byte(8'hA1, -1, "R5 read command ack");
        read_two(8'h00, pattern(1), "R1 reset read");

        // sweep every address with a random read
        for (int a = 0; a < 256; a++) begin
            bus_start();
            send_byte(8'hA0, -1, "R5 write command ack");
            send_byte(8'(a), ((a & 15) == 5) ? 3 : -1, "R6 address ack");
            bus_start();
            send_byte(8'hA1, -1, "R5 read command ack");
            read_two(pattern(a), pattern((a + 1) & 255), "R6 R4 random read");
            if ((a & 31) == 0) begin
                // R2: clock pulses after a stop are not counted
                for (int k = 0; k < 10; k++) begin
                    pulse(k[0], r);
                    chk("R2 idle pulses ignored", {7'd0, r}, 8'd1);
                end
            end
        end

        // R8: after the read at 255 the address wrapped; data register holds location 1
        bus_start();
        send_byte(8'hA1, -1, "R5 read command ack");
        read_two(pattern(1), pattern(2), "R8 wrap current read");

        // R9: overwrite one location and read it back
        init_we = 1'b1; init_addr = 8'h42; init_data = 8'h5A;
        @(negedge clk);
        init_we = 1'b0;
        bus_start();
        send_byte(8'hA0, -1, "R5 write command ack");
        send_byte(8'h42, -1, "R6 address ack");
        bus_start();
        send_byte(8'hA1, -1, "R5 read command ack");
        read_two(8'h5A, pattern(16'h43), "R9 init write");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule